// File: doc/BRIEF.md
# Miss-ratio frame allocation controller

This block watches the stream of page accesses made by a single process and decides whether that process should be given more physical frames or fewer. Each access arrives as a one-cycle strobe with a flag that says whether it missed. The controller groups the accesses into windows of a fixed length. At the close of each window it compares the fraction of misses against two limits. A high miss fraction raises the process's frame allocation by one. A low miss fraction lowers it by one. A fraction that falls between the two limits, or lands exactly on one of them, leaves the allocation unchanged.

Every change is announced by a one-cycle grow or shrink pulse, and the allocation count itself is always visible. The allocation stays inside a configured range. The block also keeps running totals of all accesses and of all misses, which are the two operands of the overall replacement ratio. Picking which frames to hand over or reclaim is left to the logic that consumes the pulses.

Top module: `frame_alloc_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `alloc_o` to `ALLOC_INIT`, both pulses to 0 and both totals to 0, and empties the current window. This holds even when reset arrives in the middle of a window.
- R2: A window closes after `WINDOW` accepted accesses (default 50). An access is accepted in a cycle where `acc_vld` is 1, and idle cycles do not count. The cycle after the one that carries the last access of the window is the decision cycle. Any pulse and the new `alloc_o` appear in the cycle after the decision cycle.
- R3: When misses*100 > `HI_PCT`*`WINDOW` (default: more than 30 of 50), `grow_o` is 1 for exactly one cycle and `alloc_o` rises by 1.
- R4: When misses*100 < `LO_PCT`*`WINDOW` (default: fewer than 10 of 50), `shrink_o` is 1 for exactly one cycle and `alloc_o` falls by 1.
- R5: A miss count that lies between the two limits, or exactly on either one (30 or 10 of 50), produces no pulse and leaves `alloc_o` unchanged.
- R6: A grow decision taken while `alloc_o` equals `ALLOC_MAX` is suppressed, so there is no pulse and no change. `alloc_o` never leaves the range [`ALLOC_MIN`, `ALLOC_MAX`].
- R7: A shrink decision taken while `alloc_o` equals `ALLOC_MIN` is suppressed, so there is no pulse and no change.
- R8: Both window counters clear in the decision cycle. An access that arrives in the decision cycle is counted as the first access of the next window.
- R9: `tot_acc_o` counts every accepted access and `tot_repl_o` counts every accepted access that missed. Each count is visible in the cycle after the access. `acc_miss` has no effect when `acc_vld` is 0.
- R10: `grow_o` and `shrink_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_vld | input | 1 | One page access in this cycle |
| acc_miss | input | 1 | The access in this cycle missed (qualified by acc_vld) |
| alloc_o | output | ALLOC_W | Current frame allocation |
| grow_o | output | 1 | One-cycle request to add a frame |
| shrink_o | output | 1 | One-cycle request to remove a frame |
| tot_acc_o | output | TOT_W | Accepted accesses since reset |
| tot_repl_o | output | TOT_W | Missed accesses since reset |

## Verification
The bench sends whole windows whose miss counts sit on either side of each limit and exactly on it (31/30 and 10/9). This separates a strict comparison from an inclusive one and shows that the dead band really holds the allocation. It also sends windows that push the allocation into both clamps, which separates a suppressed request from one that is issued. Some windows have idle cycles that carry a raised miss flag, to show that only qualified accesses count. A back-to-back pair of windows, in which the second window starts in the decision cycle, shows whether that access is kept or lost. A reset in the middle of a window shows that stale partial counts are discarded.

// File: rtl/frame_alloc_pkg.sv
package frame_alloc_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD   = 2'd0,
    DEC_GROW   = 2'd1,
    DEC_SHRINK = 2'd2
  } alloc_dec_e;
endpackage

// File: rtl/fa_window_count.sv
module fa_window_count #(
  parameter int WINDOW = 50,
  localparam int WIN_W = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic             acc_miss,
  output logic             full_o,
  output logic [WIN_W-1:0] miss_cnt_o
);
  logic [WIN_W-1:0] acc_q;
  logic [WIN_W-1:0] miss_q;

  assign full_o     = (acc_q == WIN_W'(WINDOW));
  assign miss_cnt_o = miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      miss_q <= '0;
    end else if (full_o) begin
      acc_q  <= WIN_W'(acc_vld);
      miss_q <= WIN_W'(acc_vld & acc_miss);
    end else if (acc_vld) begin
      acc_q  <= acc_q + 1'b1;
      miss_q <= miss_q + WIN_W'(acc_miss);
    end
  end

  // R2
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_q <= WIN_W'(WINDOW)) && (miss_q <= acc_q));

  // R8
  win_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && acc_vld) |=> (acc_q == WIN_W'(1)));
endmodule

// File: rtl/fa_ratio_judge.sv
module fa_ratio_judge
  import frame_alloc_pkg::*;
#(
  parameter int WINDOW = 50,
  parameter int HI_PCT = 60,
  parameter int LO_PCT = 20,
  localparam int WIN_W = $clog2(WINDOW + 1),
  localparam int PW    = WIN_W + 7
) (
  input  logic [WIN_W-1:0] miss_cnt,
  output alloc_dec_e       dec_o
);
  localparam logic [PW-1:0] HI_LIM = PW'(HI_PCT * WINDOW);
  localparam logic [PW-1:0] LO_LIM = PW'(LO_PCT * WINDOW);

  logic [PW-1:0] scaled;

  always_comb begin
    scaled = PW'(miss_cnt) * PW'(100);
    if (scaled > HI_LIM)      dec_o = DEC_GROW;
    else if (scaled < LO_LIM) dec_o = DEC_SHRINK;
    else                      dec_o = DEC_HOLD;
  end
endmodule

// File: rtl/fa_alloc_reg.sv
module fa_alloc_reg
  import frame_alloc_pkg::*;
#(
  parameter int ALLOC_MIN  = 2,
  parameter int ALLOC_MAX  = 16,
  parameter int ALLOC_INIT = 8,
  localparam int ALLOC_W = $clog2(ALLOC_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               decide,
  input  alloc_dec_e         dec,
  output logic [ALLOC_W-1:0] alloc_o,
  output logic               grow_o,
  output logic               shrink_o
);
  logic can_grow, can_shrink;

  assign can_grow   = (alloc_o < ALLOC_W'(ALLOC_MAX));
  assign can_shrink = (alloc_o > ALLOC_W'(ALLOC_MIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_o  <= ALLOC_W'(ALLOC_INIT);
      grow_o   <= 1'b0;
      shrink_o <= 1'b0;
    end else begin
      grow_o   <= 1'b0;
      shrink_o <= 1'b0;
      if (decide && dec == DEC_GROW && can_grow) begin
        alloc_o <= alloc_o + 1'b1;
        grow_o  <= 1'b1;
      end else if (decide && dec == DEC_SHRINK && can_shrink) begin
        alloc_o  <= alloc_o - 1'b1;
        shrink_o <= 1'b1;
      end
    end
  end

  // R6
  alloc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_o >= ALLOC_W'(ALLOC_MIN)) && (alloc_o <= ALLOC_W'(ALLOC_MAX)));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(grow_o && shrink_o));

  // R3
  grow_step_chk: assert property (@(posedge clk) disable iff (rst)
    grow_o |-> (alloc_o == ALLOC_W'($past(alloc_o) + 1'b1)));

  // R4
  shrink_step_chk: assert property (@(posedge clk) disable iff (rst)
    shrink_o |-> (alloc_o == ALLOC_W'($past(alloc_o) - 1'b1)));

  // R5
  alloc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!grow_o && !shrink_o) |-> $stable(alloc_o));
endmodule

// File: rtl/fa_total_count.sv
module fa_total_count #(
  parameter int TOT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic             acc_miss,
  output logic [TOT_W-1:0] tot_acc_o,
  output logic [TOT_W-1:0] tot_repl_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tot_acc_o  <= '0;
      tot_repl_o <= '0;
    end else if (acc_vld) begin
      tot_acc_o  <= tot_acc_o + 1'b1;
      tot_repl_o <= tot_repl_o + TOT_W'(acc_miss);
    end
  end

  // R9
  miss_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |=> $stable(tot_repl_o) && $stable(tot_acc_o));
endmodule

// File: rtl/frame_alloc_ctrl.sv
module frame_alloc_ctrl
  import frame_alloc_pkg::*;
#(
  parameter int WINDOW     = 50,
  parameter int HI_PCT     = 60,
  parameter int LO_PCT     = 20,
  parameter int ALLOC_MIN  = 2,
  parameter int ALLOC_MAX  = 16,
  parameter int ALLOC_INIT = 8,
  parameter int TOT_W      = 16,
  localparam int ALLOC_W   = $clog2(ALLOC_MAX + 1),
  localparam int WIN_W     = $clog2(WINDOW + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_vld,
  input  logic               acc_miss,
  output logic [ALLOC_W-1:0] alloc_o,
  output logic               grow_o,
  output logic               shrink_o,
  output logic [TOT_W-1:0]   tot_acc_o,
  output logic [TOT_W-1:0]   tot_repl_o
);
  logic             win_full;
  logic [WIN_W-1:0] win_miss;
  alloc_dec_e       dec;

  fa_window_count #(.WINDOW(WINDOW)) u_win (
    .clk        (clk),
    .rst        (rst),
    .acc_vld    (acc_vld),
    .acc_miss   (acc_miss),
    .full_o     (win_full),
    .miss_cnt_o (win_miss)
  );

  fa_ratio_judge #(.WINDOW(WINDOW), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT)) u_judge (
    .miss_cnt (win_miss),
    .dec_o    (dec)
  );

  fa_alloc_reg #(
    .ALLOC_MIN(ALLOC_MIN), .ALLOC_MAX(ALLOC_MAX), .ALLOC_INIT(ALLOC_INIT)
  ) u_alloc (
    .clk      (clk),
    .rst      (rst),
    .decide   (win_full),
    .dec      (dec),
    .alloc_o  (alloc_o),
    .grow_o   (grow_o),
    .shrink_o (shrink_o)
  );

  fa_total_count #(.TOT_W(TOT_W)) u_tot (
    .clk        (clk),
    .rst        (rst),
    .acc_vld    (acc_vld),
    .acc_miss   (acc_miss),
    .tot_acc_o  (tot_acc_o),
    .tot_repl_o (tot_repl_o)
  );

  // R2
  pulse_after_full_chk: assert property (@(posedge clk) disable iff (rst)
    (grow_o || shrink_o) |-> $past(win_full));
endmodule

// File: tb/frame_alloc_ctrl_bench.sv
module frame_alloc_ctrl_bench;
  localparam int WIN  = 50;
  localparam int AMIN = 6;
  localparam int AMAX = 10;
  localparam int AINI = 8;
  localparam int AW   = $clog2(AMAX + 1);
  localparam int TW   = 16;
  localparam int NV   = 13;
  // miss count per window, expected pulse (0 none, 1 grow, 2 shrink), expected allocation
  localparam int VM[NV] = '{31, 30, 10, 9, 50, 40, 45, 0, 20, 5, 0, 0, 0};
  localparam int VP[NV] = '{ 1,  0,  0, 2,  1,  1,  0, 2,  0, 2, 2, 2, 0};
  localparam int VA[NV] = '{ 9,  9,  9, 8,  9, 10, 10, 9,  9, 8, 7, 6, 6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_vld = 1'b0;
  logic acc_miss = 1'b0;
  logic [AW-1:0] alloc_o;
  logic grow_o, shrink_o;
  logic [TW-1:0] tot_acc_o, tot_repl_o;

  int nchk = 0;
  int nfail = 0;
  int exp_acc = 0;
  int exp_repl = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frame_alloc_ctrl #(
    .WINDOW(WIN), .HI_PCT(60), .LO_PCT(20),
    .ALLOC_MIN(AMIN), .ALLOC_MAX(AMAX), .ALLOC_INIT(AINI), .TOT_W(TW)
  ) u_frame_alloc_ctrl (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_miss(acc_miss),
    .alloc_o(alloc_o), .grow_o(grow_o), .shrink_o(shrink_o),
    .tot_acc_o(tot_acc_o), .tot_repl_o(tot_repl_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives one window; gaps insert idle cycles with the miss flag raised
  task automatic drive_window(input int m, input bit gap);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      acc_vld = 1'b1;
      acc_miss = (i < m);
      if (gap && i < WIN - 1) begin
        @(negedge clk);
        acc_vld = 1'b0;
        acc_miss = 1'b1;
      end
    end
    exp_acc += WIN;
    exp_repl += m;
    @(negedge clk);  // decision cycle
    acc_vld = 1'b0;
    acc_miss = 1'b0;
    @(negedge clk);  // result visible
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 alloc", alloc_o, AINI);
    chk("R1 grow", grow_o, 0);
    chk("R1 shrink", shrink_o, 0);
    chk("R1 tot_acc", tot_acc_o, 0);
    chk("R1 tot_repl", tot_repl_o, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      drive_window(VM[v], v[0]);
      chk("R3 grow", grow_o, VP[v] == 1);
      chk("R4 shrink", shrink_o, VP[v] == 2);
      chk("R5/R6/R7 alloc", alloc_o, VA[v]);
      chk("R10 excl", grow_o & shrink_o, 0);
      chk("R9 tot_acc", tot_acc_o, exp_acc);
      chk("R9 tot_repl", tot_repl_o, exp_repl);
    end

    // R9 miss flag ignored while idle
    repeat (5) begin
      @(negedge clk);
      acc_vld = 1'b0;
      acc_miss = 1'b1;
    end
    @(negedge clk);
    acc_miss = 1'b0;
    chk("R9 idle repl", tot_repl_o, exp_repl);
    chk("R9 idle acc", tot_acc_o, exp_acc);

    // R8 back-to-back windows: the next window starts in the decision cycle
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      acc_vld = 1'b1;
      acc_miss = (i < 35);
    end
    for (int j = 0; j < WIN; j++) begin
      @(negedge clk);
      if (j == 1) begin
        chk("R3 b2b grow", grow_o, 1);
        chk("R3 b2b alloc", alloc_o, AMIN + 1);
      end
      if (j == 2) chk("R3 one-cycle pulse", grow_o, 0);
      acc_vld = 1'b1;
      acc_miss = 1'b0;
    end
    @(negedge clk);
    acc_vld = 1'b0;
    @(negedge clk);
    chk("R8 shrink after restart", shrink_o, 1);
    chk("R8 alloc", alloc_o, AMIN);
    @(negedge clk);
    chk("R4 one-cycle pulse", shrink_o, 0);

    // R1 mid-window reset
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      acc_vld = 1'b1;
      acc_miss = 1'b1;
    end
    @(negedge clk);
    acc_vld = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mid alloc", alloc_o, AINI);
    chk("R1 mid tot_acc", tot_acc_o, 0);
    chk("R1 mid tot_repl", tot_repl_o, 0);
    exp_acc = 0;
    exp_repl = 0;
    drive_window(0, 1'b0);
    chk("R1 window emptied shrink", shrink_o, 1);
    chk("R1 window emptied alloc", alloc_o, AINI - 1);
    chk("R9 tot_acc after reset", tot_acc_o, WIN);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule